// File: doc/BRIEF.md
# Sprite Magnification Address Generator

This block turns the display's pixel and line positions into fetch addresses for a small one-bit sprite pattern of 12 columns by 16 rows. Given the sprite's screen origin, it reports whether the current position falls on the sprite. When it does, it also gives the pattern column and row to read. The downstream pattern memory and colour logic consume these outputs, so they are registered and advance only on pixel-clock enables.

A two-bit size code selects the magnification: normal, double or quadruple. At double and quadruple size, each pattern dot is repeated across 2 or 4 pixels and each pattern line across 2 or 4 scan lines. One code value is reserved and is treated as normal size. The code is sampled only at frame start, so a sprite is never drawn partly at one scale and partly at another. The magnification affects only this sprite path. Character overlay timing elsewhere is not involved.

Top module: `sprite_scaler`

## Requirements
- R1: While reset is high, and after its release until the first update, `spr_active`, `pat_col` and `pat_row` are 0, and the active magnification is normal.
- R2: With size code 2'b00 (normal), `spr_active` is 1 exactly when 0 <= hpos-org_x < 12 and 0 <= vpos-org_y < 16. In that case `pat_col` = hpos-org_x and `pat_row` = vpos-org_y.
- R3: With size code 2'b01 (double), the window is 24 pixels by 32 lines. `pat_col` = (hpos-org_x)/2 and `pat_row` = (vpos-org_y)/2, so each index is held for 2 pixels or lines.
- R4: With size code 2'b11 (quadruple), the window is 48 pixels by 64 lines. `pat_col` = (hpos-org_x)/4 and `pat_row` = (vpos-org_y)/4.
- R5: The reserved size code 2'b10 behaves exactly like normal size.
- R6: A position left of or above the origin, or at or past the scaled width or height, gives `spr_active` = 0 with `pat_col` = 0 and `pat_row` = 0.
- R7: The size code is captured only on a clock edge where `frame_start` is 1. Outputs computed on that edge still use the previous size. Changes of `size_code` at any other time have no effect.
- R8: Outputs are recomputed only on clock edges where `pix_en` is 1. On all other edges they hold their value.
- R9: `pat_col` never exceeds 11 and `pat_row` never exceeds 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel clock enable; outputs update on these edges |
| frame_start | input | 1 | Frame start pulse; loads the size code |
| hpos | input | HW (10) | Horizontal pixel position |
| vpos | input | VW (10) | Vertical line position |
| org_x | input | HW (10) | Sprite left edge |
| org_y | input | VW (10) | Sprite top edge |
| size_code | input | 2 | 00 normal, 01 double, 11 quadruple, 10 reserved (normal) |
| pat_col | output | 4 | Pattern column to fetch |
| pat_row | output | 4 | Pattern row to fetch |
| spr_active | output | 1 | Position lies on the sprite |

## Verification
A wrong latched magnification shows at the ports within one enabled pixel. Column and row indices repeat at the wrong rate, and the active window ends at the wrong pixel, which shows at the right and bottom boundary probes. A size change that leaks in outside frame start produces the wrong width on the very next enabled pixel. A broken enable shows as outputs that move during idle cycles, which is visible one cycle later. The bench probes the last pixel inside and the first pixel outside the window at every size, so an off-by-one in the window edges is caught at those probes.

// File: rtl/sprite_scaler_pkg.sv
package sprite_scaler_pkg;
  localparam int COLS = 12;
  localparam int ROWS = 16;
  localparam int CW   = $clog2(COLS);
  localparam int RW   = $clog2(ROWS);

  typedef logic [1:0] shift_t;

  // size code -> log2 of magnification; reserved value maps to normal
  function automatic shift_t code_to_shift(input logic [1:0] code);
    case (code)
      2'b01:   code_to_shift = 2'd1;
      2'b11:   code_to_shift = 2'd2;
      default: code_to_shift = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/size_latch.sv
module size_latch
  import sprite_scaler_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic [1:0] size_code,
  output shift_t     shift
);
  always_ff @(posedge clk) begin
    if (rst)              shift <= 2'd0;
    else if (frame_start) shift <= code_to_shift(size_code);
  end
endmodule

// File: rtl/span_map.sv
module span_map #(
  parameter int W    = 10,
  parameter int IW   = 4,
  parameter int BASE = 12
) (
  input  logic [W-1:0]  pos,
  input  logic [W-1:0]  org,
  input  logic [1:0]    shift,
  output logic          in_span,
  output logic [IW-1:0] idx
);
  localparam logic [W-1:0] BASE_W = W'(BASE);

  logic [W-1:0] diff;
  logic [W-1:0] extent;
  logic [W-1:0] scaled;

  always_comb begin
    diff    = pos - org;
    extent  = BASE_W << shift;
    scaled  = diff >> shift;
    in_span = (pos >= org) && (diff < extent);
    idx     = in_span ? scaled[IW-1:0] : '0;
  end
endmodule

// File: rtl/sprite_scaler.sv
module sprite_scaler
  import sprite_scaler_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          frame_start,
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  input  logic [HW-1:0] org_x,
  input  logic [VW-1:0] org_y,
  input  logic [1:0]    size_code,
  output logic [CW-1:0] pat_col,
  output logic [RW-1:0] pat_row,
  output logic          spr_active
);
  shift_t        shift;
  logic          h_in, v_in;
  logic [CW-1:0] col_n;
  logic [RW-1:0] row_n;

  size_latch u_size (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .size_code(size_code), .shift(shift)
  );

  span_map #(.W(HW), .IW(CW), .BASE(COLS)) u_h (
    .pos(hpos), .org(org_x), .shift(shift), .in_span(h_in), .idx(col_n)
  );

  span_map #(.W(VW), .IW(RW), .BASE(ROWS)) u_v (
    .pos(vpos), .org(org_y), .shift(shift), .in_span(v_in), .idx(row_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spr_active <= 1'b0;
      pat_col    <= '0;
      pat_row    <= '0;
    end else if (pix_en) begin
      spr_active <= h_in && v_in;
      pat_col    <= (h_in && v_in) ? col_n : '0;
      pat_row    <= (h_in && v_in) ? row_n : '0;
    end
  end
endmodule

// File: rtl/sprite_scaler_chk.sv
module sprite_scaler_chk
  import sprite_scaler_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic [CW-1:0] pat_col,
  input logic [RW-1:0] pat_row,
  input logic          spr_active
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !spr_active |-> (pat_col == '0 && pat_row == '0)); // R6

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
    pat_col <= CW'(COLS - 1)); // R9

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    pat_row <= RW'(ROWS - 1)); // R9

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(pat_col) && $stable(pat_row) && $stable(spr_active))); // R8
endmodule

bind sprite_scaler sprite_scaler_chk u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en),
  .pat_col(pat_col), .pat_row(pat_row), .spr_active(spr_active)
);

// File: tb/sim_sprite_scaler.sv
`timescale 1ns/1ps
module sim_sprite_scaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_en = 1'b0;
  logic       frame_start = 1'b0;
  logic [9:0] hpos = '0, vpos = '0, org_x = '0, org_y = '0;
  logic [1:0] size_code = 2'b00;
  logic [3:0] pat_col, pat_row;
  logic       spr_active;

  typedef struct packed {
    logic       act;
    logic [3:0] col;
    logic [3:0] row;
    logic [7:0] req;
  } exp_t;

  exp_t q[$];
  exp_t last_exp;
  int   n_vec = 0;
  int   n_bad = 0;
  int   cur_shift = 0;   // bench model of latched magnification
  bit   done = 1'b0;

  always #5 clk = ~clk;

  sprite_scaler u0 (
    .clk(clk), .rst(rst), .pix_en(pix_en), .frame_start(frame_start),
    .hpos(hpos), .vpos(vpos), .org_x(org_x), .org_y(org_y),
    .size_code(size_code), .pat_col(pat_col), .pat_row(pat_row),
    .spr_active(spr_active)
  );

  function automatic exp_t model(int h, int v, int ox, int oy, int sh, int r);
    exp_t e;
    int dx = h - ox;
    int dy = v - oy;
    int sc = 1 << sh;
    e.req = 8'(r);
    if (dx >= 0 && dx < 12*sc && dy >= 0 && dy < 16*sc) begin
      e.act = 1'b1; e.col = 4'(dx / sc); e.row = 4'(dy / sc);
    end else begin
      e.act = 1'b0; e.col = '0; e.row = '0;
    end
    return e;
  endfunction

  task automatic pix(int h, int v, int r);
    @(negedge clk);
    hpos = 10'(h); vpos = 10'(v); pix_en = 1'b1; frame_start = 1'b0;
    last_exp = model(h, v, org_x, org_y, cur_shift, r);
    q.push_back(last_exp);
  endtask

  task automatic idle(int h, int v, int r);
    exp_t e;
    @(negedge clk);
    hpos = 10'(h); vpos = 10'(v); pix_en = 1'b0; frame_start = 1'b0;
    e = last_exp; e.req = 8'(r);
    q.push_back(e);
  endtask

  // frame start with pix_en low: latch loads, outputs hold
  task automatic new_frame(logic [1:0] code, int r);
    exp_t e;
    @(negedge clk);
    size_code = code; pix_en = 1'b0; frame_start = 1'b1;
    e = last_exp; e.req = 8'(r);
    q.push_back(e);
    cur_shift = (code == 2'b01) ? 1 : (code == 2'b11) ? 2 : 0;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_vec++;
        if (spr_active !== e.act || pat_col !== e.col || pat_row !== e.row) begin
          n_bad++;
          $display("FAIL R%0d: act/col/row = %b/%0d/%0d expected %b/%0d/%0d",
                   e.req, spr_active, pat_col, pat_row, e.act, e.col, e.row);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run hung, act/col/row = %b/%0d/%0d expected completion",
             spr_active, pat_col, pat_row);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    last_exp = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_vec++;
    if (spr_active !== 1'b0 || pat_col !== 4'd0 || pat_row !== 4'd0) begin
      n_bad++;
      $display("FAIL R1: act/col/row = %b/%0d/%0d expected 0/0/0", spr_active, pat_col, pat_row);
    end
    rst = 1'b0;
    org_x = 10'd100; org_y = 10'd50;
    // R1: latched size is normal after reset; R2 normal window
    pix(100, 50, 1);
    pix(111, 50, 2);
    pix(112, 50, 6);  // R6 first pixel past width
    pix(99, 55, 6);   // R6 left of origin
    pix(105, 65, 2);
    pix(105, 66, 6);  // R6 below height
    pix(105, 49, 6);  // R6 above origin
    // R8: idle cycles hold
    idle(105, 60, 8);
    idle(0, 0, 8);
    pix(103, 57, 2);
    idle(500, 500, 8);
    // R7: size change without frame start is ignored
    @(negedge clk); size_code = 2'b11; pix_en = 1'b0;
    pix(112, 50, 7);
    pix(111, 65, 7);
    // R3: double
    new_frame(2'b01, 7);
    for (int i = 0; i < 26; i++) pix(100 + i, 50, 3);
    pix(123, 81, 3);
    pix(123, 82, 3);
    pix(100, 51, 3);
    // R4: quadruple
    new_frame(2'b11, 4);
    for (int i = 0; i < 50; i++) pix(100 + i, 53, 4);
    pix(147, 113, 4);
    pix(147, 114, 4);
    pix(102, 110, 4);
    // R5: reserved code behaves as normal
    new_frame(2'b10, 5);
    pix(111, 65, 5);
    pix(112, 50, 5);
    pix(100, 66, 5);
    // R7: frame start edge itself uses old size, new size afterwards
    org_x = 10'd0; org_y = 10'd0;
    @(negedge clk);
    size_code = 2'b01; frame_start = 1'b1; pix_en = 1'b1; hpos = 10'd13; vpos = 10'd0;
    last_exp = model(13, 0, 0, 0, cur_shift, 7);
    q.push_back(last_exp);
    cur_shift = 1;
    pix(13, 0, 7);
    pix(23, 31, 3);
    @(negedge clk); pix_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule